// File: doc/BRIEF.md
# Multichannel Beam Summation Combiner

The combiner merges up to four complex baseband streams into a single beam stream. Each input lane carries a signed 16-bit in-phase sample, a signed 16-bit quadrature sample and a valid strobe. A programmable lane mask chooses which lanes take part in the sum. Lanes left out of the mask add nothing, and their strobes are ignored.

The sum is carried in a widened accumulator, so no intermediate overflow is possible. An unsigned gain in Q2.14 format then scales it. This gain makes up for the growth that summing adds. The scaled value is rounded half-up and saturated back to signed 16 bits. The result goes into a one-entry output register with a valid/ready handshake. While that register is full and not being drained, all input lanes are stalled.

A small register port sets the mask and the gain and reads them back.

Top module: `beam_combiner`

## Requirements
- R1: After reset, out_valid_o is 0 and ch_ready_o is 1. The mask reads back as 0xF (all four lanes enabled). The gain reads back as 0x4000 (unity).
- R2: The sum includes only lanes whose mask bit is set. Lane n uses bit n, and lane n's samples sit at bits [16n+15:16n] of each data bus. A masked-off lane adds zero to the sum.
- R3: A sum is taken only in a cycle where every enabled lane has its valid bit high. The valid bits of disabled lanes have no effect. If any enabled lane is not valid, no output sample is produced.
- R4: Each component is computed as floor((sum * gain + 8192) / 16384), where gain is an unsigned Q2.14 value. Ties therefore round toward plus infinity.
- R5: A result above 32767 becomes 32767, and a result below -32768 becomes -32768.
- R6: With the mask set to zero, every accepting cycle produces a valid output sample of value 0 in both components, whatever the input strobes.
- R7: While out_valid_o is 1 and out_ready_i is 0, the output sample stays unchanged and ch_ready_o is 0.
- R8: A sum accepted on one clock edge shows up on out_i_o and out_q_o with out_valid_o high right after that edge. If out_ready_i is high at an edge, a new sample can be accepted on the same edge that the current one is drained.
- R9: Register map, with cfg_addr_i values: address 0 holds the mask in bits [3:0], and address 1 holds the gain in bits [15:0]. Each register reads back its value. Writes to addresses 2 and 3 are ignored, and those addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_i_i | input | 64 | In-phase samples of the four lanes, packed |
| ch_q_i | input | 64 | Quadrature samples of the four lanes, packed |
| ch_valid_i | input | 4 | Per-lane sample strobe |
| ch_ready_o | output | 1 | Lanes may present samples (low stalls them) |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data for cfg_addr_i |
| out_i_o | output | 16 | Combined in-phase sample |
| out_q_o | output | 16 | Combined quadrature sample |
| out_valid_o | output | 1 | Output sample present |
| out_ready_i | input | 1 | Consumer accepts the output sample |

## Verification
The hardest case to reach from the ports is a stalled output register receiving fresh, fully valid input. It must hold the old sample for several cycles, and then, on the edge where ready returns, drain that sample and accept the new one in the same cycle. The stimulus drops out_ready_i, pushes one sum into the register, and keeps a different valid sum on the lanes across several stalled cycles. It then raises ready and checks that the second sum appears on the very next edge. Rounding ties are reached by setting the gain to one half and 1.5 and feeding odd sums of both signs.

// File: rtl/bc_pkg.sv
package bc_pkg;
  parameter int unsigned BC_NCH   = 4;
  parameter int unsigned BC_DW    = 16;
  parameter int unsigned BC_GW    = 16;
  parameter int unsigned BC_GFRAC = 14;
  parameter int unsigned BC_BUSW  = 16;
  parameter int unsigned BC_AW    = 2;

  typedef enum logic [BC_AW-1:0] {
    REG_MASK = 2'd0,
    REG_GAIN = 2'd1
  } reg_addr_e;
endpackage

// File: rtl/bc_cfg_regs.sv
module bc_cfg_regs
  import bc_pkg::*;
#(
  parameter int unsigned NCH  = BC_NCH,
  parameter int unsigned GW   = BC_GW,
  parameter int unsigned BUSW = BC_BUSW,
  parameter int unsigned AW   = BC_AW,
  parameter int unsigned GFRAC = BC_GFRAC
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [BUSW-1:0] wdata_i,
  output logic [BUSW-1:0] rdata_o,
  output logic [NCH-1:0]  mask_o,
  output logic [GW-1:0]   gain_o
);
  localparam logic [GW-1:0] GAIN_ONE = GW'(1) << GFRAC;

  logic [NCH-1:0] mask_q;
  logic [GW-1:0]  gain_q;
  logic           unused_bits;

  assign unused_bits = ^wdata_i[BUSW-1:NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      gain_q <= GAIN_ONE;
    end else if (we_i) begin
      case (addr_i)
        REG_MASK: mask_q <= wdata_i[NCH-1:0];
        REG_GAIN: gain_q <= wdata_i[GW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_MASK: rdata_o = BUSW'(mask_q);
      REG_GAIN: rdata_o = BUSW'(gain_q);
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
  assign gain_o = gain_q;

  p_mask_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_MASK) |=> (mask_o == $past(wdata_i[NCH-1:0])));

  p_ignored_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[1]) |=> ($stable(mask_o) && $stable(gain_o)));
endmodule

// File: rtl/bc_sum_tree.sv
module bc_sum_tree
  import bc_pkg::*;
#(
  parameter int unsigned NCH  = BC_NCH,
  parameter int unsigned DW   = BC_DW,
  parameter int unsigned ACCW = DW + $clog2(NCH)
) (
  input  logic [NCH*DW-1:0]       data_i,
  input  logic [NCH-1:0]          mask_i,
  output logic signed [ACCW-1:0]  sum_o
);
  logic signed [ACCW-1:0] term [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_term
    assign term[c] = mask_i[c] ? ACCW'($signed(data_i[c*DW +: DW])) : '0;
  end

  always_comb begin
    sum_o = '0;
    for (int c = 0; c < NCH; c++) sum_o = sum_o + term[c];
  end
endmodule

// File: rtl/bc_gain_sat.sv
module bc_gain_sat
  import bc_pkg::*;
#(
  parameter int unsigned ACCW  = BC_DW + 2,
  parameter int unsigned GW    = BC_GW,
  parameter int unsigned GFRAC = BC_GFRAC,
  parameter int unsigned DW    = BC_DW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [ACCW-1:0] sum_i,
  input  logic [GW-1:0]          gain_i,
  output logic signed [DW-1:0]   res_o
);
  localparam int unsigned PW = ACCW + GW + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [PW-1:0] MINV = ~MAXV;
  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (GFRAC-1));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] scaled;

  assign prod   = PW'(sum_i) * $signed({1'b0, gain_i});
  assign rnd    = prod + HALF;
  assign scaled = rnd >>> GFRAC;

  always_comb begin
    if (scaled > MAXV)      res_o = MAXV[DW-1:0];
    else if (scaled < MINV) res_o = MINV[DW-1:0];
    else                    res_o = scaled[DW-1:0];
  end

  p_sign_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scaled >= 0) |-> !res_o[DW-1]);

  p_neg_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scaled < 0) |-> res_o[DW-1]);
endmodule

// File: rtl/beam_combiner.sv
module beam_combiner
  import bc_pkg::*;
#(
  parameter int unsigned NCH   = BC_NCH,
  parameter int unsigned DW    = BC_DW,
  parameter int unsigned GW    = BC_GW,
  parameter int unsigned GFRAC = BC_GFRAC,
  parameter int unsigned BUSW  = BC_BUSW,
  parameter int unsigned AW    = BC_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH*DW-1:0] ch_i_i,
  input  logic [NCH*DW-1:0] ch_q_i,
  input  logic [NCH-1:0]    ch_valid_i,
  output logic              ch_ready_o,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [BUSW-1:0]   cfg_wdata_i,
  output logic [BUSW-1:0]   cfg_rdata_o,
  output logic [DW-1:0]     out_i_o,
  output logic [DW-1:0]     out_q_o,
  output logic              out_valid_o,
  input  logic              out_ready_i
);
  localparam int unsigned ACCW = DW + $clog2(NCH);
  localparam int unsigned NCMP = 2;

  logic [NCH-1:0]         mask;
  logic [GW-1:0]          gain;
  logic [NCH*DW-1:0]      cmp_data [NCMP];
  logic signed [ACCW-1:0] cmp_sum  [NCMP];
  logic signed [DW-1:0]   cmp_res  [NCMP];
  logic [DW-1:0]          out_q    [NCMP];
  logic                   valid_q;
  logic                   lanes_ok;
  logic                   take;

  bc_cfg_regs #(
    .NCH(NCH), .GW(GW), .BUSW(BUSW), .AW(AW), .GFRAC(GFRAC)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .mask_o  (mask),
    .gain_o  (gain)
  );

  assign cmp_data[0] = ch_i_i;
  assign cmp_data[1] = ch_q_i;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    bc_sum_tree #(.NCH(NCH), .DW(DW), .ACCW(ACCW)) u_sum (
      .data_i (cmp_data[k]),
      .mask_i (mask),
      .sum_o  (cmp_sum[k])
    );

    bc_gain_sat #(.ACCW(ACCW), .GW(GW), .GFRAC(GFRAC), .DW(DW)) u_gain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sum_i  (cmp_sum[k]),
      .gain_i (gain),
      .res_o  (cmp_res[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   out_q[k] <= '0;
      else if (take) out_q[k] <= cmp_res[k];
    end
  end

  // disabled lanes count as always present
  assign lanes_ok   = &(ch_valid_i | ~mask);
  assign ch_ready_o = !valid_q || out_ready_i;
  assign take       = ch_ready_o && lanes_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          valid_q <= 1'b0;
    else if (take)        valid_q <= 1'b1;
    else if (out_ready_i) valid_q <= 1'b0;
  end

  assign out_valid_o = valid_q;
  assign out_i_o     = out_q[0];
  assign out_q_o     = out_q[1];

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_i_o) && $stable(out_q_o)));

  p_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> out_valid_o);

  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lanes_ok && ch_ready_o) |=> !out_valid_o);

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mask == '0) |=> (out_i_o == '0 && out_q_o == '0));
endmodule

// File: tb/beam_combiner_bench.sv
module beam_combiner_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ch_i = '0;
  logic [63:0] ch_q = '0;
  logic [3:0]  ch_valid = '0;
  logic        ch_ready;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [15:0] out_i;
  logic [15:0] out_q;
  logic        out_valid;
  logic        out_ready = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beam_combiner u_beam_combiner (
    .clk_i(clk), .rst_ni(rst_n),
    .ch_i_i(ch_i), .ch_q_i(ch_q), .ch_valid_i(ch_valid), .ch_ready_o(ch_ready),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .out_i_o(out_i), .out_q_o(out_q), .out_valid_o(out_valid),
    .out_ready_i(out_ready)
  );

  function automatic int model(int s, int g);
    longint p = longint'(s) * longint'(g) + 64'sd8192;
    p = p >>> 14;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic put(int c, int iv, int qv);
    ch_i[c*16 +: 16] = iv[15:0];
    ch_q[c*16 +: 16] = qv[15:0];
  endtask

  task automatic cfg_write(logic [1:0] a, logic [15:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(logic [1:0] a, output int v);
    cfg_addr = a; #1;
    v = int'(cfg_rdata);
  endtask

  // present lanes for one edge, then withdraw strobes
  task automatic step(logic [3:0] v);
    ch_valid = v;
    @(posedge clk); #1;
    ch_valid = '0;
  endtask

  task automatic t_reset();
    int v;
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 ready", int'(ch_ready), 1);
    cfg_read(2'd0, v); chk("R1 mask", v, 15);
    cfg_read(2'd1, v); chk("R1 gain", v, 16384);
  endtask

  task automatic t_sum_all();
    put(0, 100, -1); put(1, 200, -2); put(2, -50, -3); put(3, 7, -4);
    step(4'hF);
    chk("R8 valid", int'(out_valid), 1);
    chk("R2 i", int'($signed(out_i)), 257);
    chk("R2 q", int'($signed(out_q)), -10);
  endtask

  task automatic t_mask_subset();
    cfg_write(2'd0, 16'h0005);
    put(0, 1000, 5); put(1, 9999, 9999); put(2, -300, 5); put(3, 9999, 9999);
    step(4'b0101);
    chk("R3 disabled strobes ignored", int'(out_valid), 1);
    chk("R2 subset i", int'($signed(out_i)), 700);
    chk("R2 subset q", int'($signed(out_q)), 10);
    step(4'b1011);
    chk("R3 enabled lane missing", int'(out_valid), 0);
    cfg_write(2'd0, 16'h000F);
  endtask

  task automatic t_round();
    put(1, 0, 0); put(2, 0, 0); put(3, 0, 0);
    cfg_write(2'd1, 16'h2000);
    put(0, 3, -3);
    step(4'hF);
    chk("R4 half +1.5", int'($signed(out_i)), model(3, 8192));
    chk("R4 half -1.5", int'($signed(out_q)), -1);
    cfg_write(2'd1, 16'h6000);
    put(0, 5, -5);
    step(4'hF);
    chk("R4 x1.5 i", int'($signed(out_i)), 8);
    chk("R4 x1.5 q", int'($signed(out_q)), -7);
  endtask

  task automatic t_sat();
    cfg_write(2'd1, 16'h4000);
    for (int c = 0; c < 4; c++) put(c, 32767, -32768);
    step(4'hF);
    chk("R5 pos sum", int'($signed(out_i)), 32767);
    chk("R5 neg sum", int'($signed(out_q)), -32768);
    cfg_write(2'd1, 16'hFFFF);
    for (int c = 1; c < 4; c++) put(c, 0, 0);
    put(0, 10000, -10000);
    step(4'hF);
    chk("R5 gain pos", int'($signed(out_i)), model(10000, 65535));
    chk("R5 gain neg", int'($signed(out_q)), -32768);
    cfg_write(2'd1, 16'h4000);
  endtask

  task automatic t_zero_mask();
    cfg_write(2'd0, 16'h0000);
    put(0, 1234, 4321);
    ch_valid = '0;
    @(posedge clk); #1;
    chk("R6 valid", int'(out_valid), 1);
    chk("R6 i", int'($signed(out_i)), 0);
    chk("R6 q", int'($signed(out_q)), 0);
    @(posedge clk); #1;
    chk("R6 repeat", int'(out_valid), 1);
    cfg_write(2'd0, 16'h000F);
    @(posedge clk); #1;
  endtask

  task automatic t_backpressure();
    for (int c = 1; c < 4; c++) put(c, 0, 0);
    out_ready = 1'b0;
    put(0, 111, 222);
    ch_valid = 4'hF;
    @(posedge clk); #1;
    chk("R8 stalled load", int'($signed(out_i)), 111);
    put(0, 333, 444);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R7 ready low", int'(ch_ready), 0);
      chk("R7 hold i", int'($signed(out_i)), 111);
      chk("R7 hold q", int'($signed(out_q)), 222);
    end
    out_ready = 1'b1;
    @(posedge clk); #1;
    ch_valid = '0;
    chk("R8 drain+take i", int'($signed(out_i)), 333);
    chk("R8 drain+take v", int'(out_valid), 1);
    @(posedge clk); #1;
    chk("R8 empty", int'(out_valid), 0);
  endtask

  task automatic t_regs();
    int v;
    cfg_write(2'd0, 16'h0006);
    cfg_write(2'd2, 16'h1234);
    cfg_write(2'd3, 16'hFFFF);
    cfg_read(2'd0, v); chk("R9 mask kept", v, 6);
    cfg_read(2'd1, v); chk("R9 gain kept", v, 16384);
    cfg_read(2'd2, v); chk("R9 addr2 zero", v, 0);
    put(0, 50, 0); put(1, 10, 1); put(2, 20, 2); put(3, 40, 3);
    step(4'b0110);
    chk("R9 mask effect", int'($signed(out_i)), 30);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_sum_all();
    t_mask_subset();
    t_round();
    t_sat();
    t_zero_mask();
    t_backpressure();
    t_regs();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule